// File: doc/BRIEF.md
# Selectable serial bit-rate generator

This block turns the oscillator clock into the serial clock that a two-wire bus master drives. A 3-bit rate code chooses the clock rate. Seven of the eight codes divide the oscillator by a fixed amount, and the divisors do not rise steadily with the code. The eighth code uses an external 8-bit auto-reload timer instead: each overflow pulse from the timer advances an internal count, and the serial clock changes level after a set number of overflows. In every mode the output has a 50% duty cycle.

A second output, computed from the oscillator frequency parameter, flags a selected rate that is faster than the 100 kHz standard-mode limit. Outside master mode the serial clock stays high. A new rate code is picked up only at the rising edge of the serial clock, which is the point where a period ends, so a code change never produces a short pulse.

Top module: `serial_rate_gen`

## Requirements
- R1: While `rst` is sampled high on a clock edge, `scl_out` is 1 after that edge.
- R2: While `master_en` is 0, `scl_out` stays at 1. Overflow pulses and code changes have no effect in this state.
- R3: In master mode with fixed code c (0 to 6), the low phase and the high phase of `scl_out` each last H oscillator cycles. H is 128, 112, 96, 80, 480, 60 and 30 for c = 0 through 6, which is half of the divisors 256, 224, 192, 160, 960, 120 and 60.
- R4: With code 7, `scl_out` changes level on every OVF_HALF-th (default 4) cycle in which `ovf_pulse` is 1.
- R5: With a fixed code, `ovf_pulse` does not change the output timing.
- R6: A change of `rate_sel` during master mode takes effect at the next rising edge of `scl_out`. The low phase that runs when the change is made keeps the old length.
- R7: For a fixed code, `too_fast` is 1 exactly when FOSC_HZ / divisor > LIMIT_HZ (default 12 MHz and 100 kHz, so only code 6 is flagged).
- R8: For code 7, `too_fast` is 1 exactly when FOSC_HZ > LIMIT_HZ × 96 × (256 − `reload`). At the default frequency this holds for `reload` = 255 only.
- R9: When `master_en` rises, the code on `rate_sel` is loaded at once. `scl_out` first falls on the H-th clock edge at which `master_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| master_en | input | 1 | Enables serial clock generation (master mode) |
| rate_sel | input | 3 | Rate code; 7 selects timer overflow mode |
| reload | input | 8 | Reload value of the external timer (used for the rate flag) |
| ovf_pulse | input | 1 | One-cycle pulse at each timer overflow |
| scl_out | output | 1 | Serial clock, 50% duty |
| too_fast | output | 1 | Selected rate exceeds LIMIT_HZ |

## Verification
The assertions assume three things about the inputs: `ovf_pulse` lasts one cycle, `rate_sel` is meant to be sampled only at period boundaries, and reset is held from time zero. The bench drives the overflow pulse as a single cycle in every third clock, which keeps the timer-mode periods exact. It changes the code in the middle of a high phase, which tests the deferred pickup without racing a boundary. It also runs the overflow pulses during the fixed-code and disabled tests, which shows that they are ignored there.

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
  parameter int unsigned FOSC_HZ     = 12_000_000,
  parameter int unsigned LIMIT_HZ    = 100_000,
  parameter int unsigned OVF_HALF    = 4,
  parameter int unsigned TIMER_SCALE = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       master_en,
  input  logic [2:0] rate_sel,
  input  logic [7:0] reload,
  input  logic       ovf_pulse,
  output logic       scl_out,
  output logic       too_fast
);
  localparam int unsigned MAXH = (OVF_HALF > 480) ? OVF_HALF : 480;
  localparam int unsigned CW   = $clog2(MAXH + 1);

  function automatic logic [10:0] div_of(input logic [2:0] s);
    case (s)
      3'd0: div_of = 11'd256;
      3'd1: div_of = 11'd224;
      3'd2: div_of = 11'd192;
      3'd3: div_of = 11'd160;
      3'd4: div_of = 11'd960;
      3'd5: div_of = 11'd120;
      default: div_of = 11'd60;
    endcase
  endfunction

  function automatic logic [CW-1:0] half_of(input logic [2:0] s);
    if (s == 3'd7) half_of = CW'(OVF_HALF);
    else           half_of = CW'(div_of(s) >> 1);
  endfunction

  logic [2:0]    cur_sel;
  logic [CW-1:0] cnt;
  logic          scl_q;

  wire timer_mode = (cur_sel == 3'd7);
  wire step       = master_en && (!timer_mode || ovf_pulse);
  wire wrap       = step && (cnt == half_of(cur_sel) - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !master_en) begin
      scl_q   <= 1'b1;
      cnt     <= '0;
      cur_sel <= rate_sel;
    end else if (wrap) begin
      cnt   <= '0;
      scl_q <= ~scl_q;
      if (!scl_q) cur_sel <= rate_sel;
    end else if (step) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign scl_out = scl_q;

  wire [63:0] fosc_w  = 64'(FOSC_HZ);
  wire [63:0] lim_w   = 64'(LIMIT_HZ);
  wire [63:0] tdiv_w  = 64'(TIMER_SCALE) * (64'd256 - 64'(reload));
  assign too_fast = (rate_sel == 3'd7) ? (fosc_w > lim_w * tdiv_w)
                                       : (fosc_w > lim_w * 64'(div_of(rate_sel)));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> scl_out);

  // R4
  timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (master_en && timer_mode && !ovf_pulse) |=> $stable(scl_out));

  // R6
  code_latch_chk: assert property (@(posedge clk) disable iff (rst)
    master_en |=> ($stable(cur_sel) || $rose(scl_out) || !master_en));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < half_of(cur_sel));
endmodule

// File: tb/serial_rate_gen_tb.sv
module serial_rate_gen_tb_top;
  logic clk = 0, rst = 1, master_en = 0, ovf_pulse = 0;
  logic [2:0] rate_sel = 0;
  logic [7:0] reload = 0;
  logic scl_out, too_fast;
  int tests = 0, fails = 0, cyc = 0, ph = 0;

  serial_rate_gen dut_i (.clk(clk), .rst(rst), .master_en(master_en),
    .rate_sel(rate_sel), .reload(reload), .ovf_pulse(ovf_pulse),
    .scl_out(scl_out), .too_fast(too_fast));

  always #4 clk = ~clk;

  localparam int NV = 10;
  localparam int VSEL  [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 7, 7};
  localparam int VREL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 255, 254, 0};
  localparam int VHALF [NV] = '{128, 112, 96, 80, 480, 60, 30, 12, 12, 12};
  localparam int VFAST [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0};

  initial forever begin
    @(negedge clk);
    cyc++;
    ph = (ph + 1) % 3;
    ovf_pulse = (ph == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lo, output int hi);
    int g = 0;
    while (scl_out !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    while (scl_out !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
    lo = 0;
    while (scl_out === 1'b0 && g < 3000) begin @(negedge clk); lo++; g++; end
    hi = 0;
    while (scl_out === 1'b1 && g < 3000) begin @(negedge clk); hi++; g++; end
  endtask

  initial begin
    int lo, hi, n;
    repeat (3) @(negedge clk);
    check("R1 reset level", int'(scl_out), 1);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      master_en = 0;
      rate_sel = 3'(VSEL[i]);
      reload = 8'(VREL[i]);
      @(negedge clk);
      check(VSEL[i] == 7 ? "R8 flag" : "R7 flag", int'(too_fast), VFAST[i]);
      master_en = 1;
      measure(lo, hi);
      check(VSEL[i] == 7 ? "R4 low" : "R3/R5 low", lo, VHALF[i]);
      check(VSEL[i] == 7 ? "R4 high" : "R3/R5 high", hi, VHALF[i]);
    end

    master_en = 0; rate_sel = 3'd6;
    @(negedge clk);
    master_en = 1;
    n = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (scl_out === 1'b1) n++; else break;
    end
    check("R9 first high", n, 29);

    while (scl_out !== 1'b1) @(negedge clk);
    repeat (5) @(negedge clk);
    rate_sel = 3'd5;
    measure(lo, hi);
    check("R6 old low kept", lo, 30);
    check("R6 new high", hi, 60);
    measure(lo, hi);
    check("R6 new low", lo, 60);

    master_en = 0;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      rate_sel = 3'(k % 8);
      if (scl_out !== 1'b1) n++;
    end
    check("R2 held high", n, 0);

    master_en = 1; rate_sel = 3'd6;
    repeat (40) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("R1 reset mid-run", int'(scl_out), 1);
    rst = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    tests++; fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule